// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It sits behind a fixed divide-by-8 prescaler and divides that prescaled oscillator clock by a programmable ratio N = 32M + S. A phase detector compares its output against the reference. Internally a dual-modulus stage counts either 32 or 33 input cycles per sub-period. A swallow counter selects the 33 setting for the first S sub-periods of every output period. A main counter ends the period after M sub-periods. The output is a single-cycle comparison pulse once per N input cycles, so the total ratio seen from the oscillator is 8·(32M + S).

A new ratio is requested with a one-cycle load strobe. The strobe carries M, S and a width flag. When the flag is low, M is treated as a 9-bit value: its top bit is ignored. An accepted request is held and takes effect only at the next period boundary. A request whose effective M is below 32 is refused and flagged, and the ratio in use does not change. The load strobe is a plain control input with no back-pressure: every strobe is acted on in the cycle it is seen. No data stream crosses the block's edge, so no valid/ready pair is present.

The widths are parameters. `SW_W` sets the swallow counter width, and with it the modulus pair 2^SW_W / 2^SW_W+1 and the lower bound 2^SW_W on M. `M_W` sets the main counter width. The defaults give 32/33, a 10-bit M, and a lower bound of 32.

Top module: `swallow_divider`

## Requirements
- R1: The number of input clock cycles between consecutive rising edges of `fb_pulse` equals 32·M + S, where M and S form the ratio in force for that period (2^SW_W·M + S in general).
- R2: `fb_pulse` is high for exactly one input clock cycle per output period.
- R3: An accepted request never changes the period in progress. It takes effect from the period that starts at the next boundary. A request seen in the same cycle as a boundary waits for the boundary after it.
- R4: When several accepted requests arrive within one period, the last one is the one applied at the boundary.
- R5: With `ld_wide` = 0, bit M_W-1 of `ld_main` is treated as zero, and the remaining bits form M (range 32..511 at defaults). With `ld_wide` = 1 all bits of `ld_main` are used (32..1023).
- R6: A request whose effective M is below 32 (2^SW_W) raises `range_err` for one cycle, in the cycle after the strobe. The ratio in force is unchanged, and an earlier accepted request that is still waiting is kept.
- R7: During and right after reset, `fb_pulse` and `range_err` are low and the ratio is RST_M/RST_S. The first pulse rises on the N-th rising clock edge after reset is released.
- R8: `range_err` is never raised except in the cycle after a load strobe, and an accepted request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div8 | input | 1 | Prescaled oscillator clock (oscillator / 8) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_req | input | 1 | One-cycle strobe requesting a new ratio |
| ld_wide | input | 1 | 1: M uses all M_W bits; 0: top bit of M forced to zero |
| ld_main | input | M_W | Main counter value M |
| ld_swal | input | SW_W | Swallow counter value S |
| fb_pulse | output | 1 | One-cycle comparison pulse per output period |
| range_err | output | 1 | One-cycle flag: last request had M below the lower bound |

## Verification
The bench builds the divider with SW_W = 3 and M_W = 7, which gives an 8/9 modulus pair, M from 8 to 127, and a narrow-mode limit of 63. With RST_M = 8 the reset period is 64 cycles. Periods then range from 64 to 1023 input cycles, so the extremes of M and S, the masked top bit and the rejection threshold can all be reached many times within the cycle budget. It also places requests exactly in the boundary cycle and stacks several requests in one period, to check the deferral and last-request ordering.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;
  // Which modulus the dual-modulus stage uses for the current sub-period.
  typedef enum logic {
    MOD_BASE = 1'b0,  // 2^SW_W cycles
    MOD_PLUS = 1'b1   // 2^SW_W + 1 cycles
  } modsel_e;
endpackage

// File: rtl/sw_ratio_gate.sv
// Range check and deferred holding of ratio requests.
module sw_ratio_gate #(
  parameter int unsigned M_W  = 10,
  parameter int unsigned SW_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_req,
  input  logic            ld_wide,
  input  logic [M_W-1:0]  ld_main,
  input  logic [SW_W-1:0] ld_swal,
  input  logic            take,
  output logic            pend_vld,
  output logic [M_W-1:0]  pend_main,
  output logic [SW_W-1:0] pend_swal,
  output logic            range_err
);
  localparam int unsigned   M_MIN   = 1 << SW_W;
  localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

  logic [M_W-1:0] m_eff;
  logic           m_ok;

  generate
    if (M_W > 1) begin : g_mask
      always_comb m_eff = ld_wide ? ld_main : {1'b0, ld_main[M_W-2:0]};
    end else begin : g_nomask
      always_comb m_eff = ld_wide ? ld_main : '0;
    end
  endgenerate

  assign m_ok = (m_eff >= M_FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_main <= '0;
      pend_swal <= '0;
      range_err <= 1'b0;
    end else begin
      range_err <= ld_req && !m_ok;
      if (ld_req && m_ok) begin
        pend_vld  <= 1'b1;
        pend_main <= m_eff;
        pend_swal <= ld_swal;
      end else if (take) begin
        pend_vld  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sw_dual_modulus.sv
// Counts 2^SW_W or 2^SW_W+1 input cycles per sub-period.
module sw_dual_modulus
  import sw_div_pkg::*;
#(
  parameter int unsigned SW_W = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  modsel_e sel,
  output logic    tick
);
  localparam logic [SW_W:0] LAST_BASE = {1'b0, {SW_W{1'b1}}};
  localparam logic [SW_W:0] LAST_PLUS = {1'b1, {SW_W{1'b0}}};

  logic [SW_W:0] cnt;
  logic [SW_W:0] last;

  assign last = (sel == MOD_PLUS) ? LAST_PLUS : LAST_BASE;
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sw_count_chain.sv
// Main and swallow counters, modulus control, boundary and ratio update.
module sw_count_chain
  import sw_div_pkg::*;
#(
  parameter int unsigned M_W   = 10,
  parameter int unsigned SW_W  = 5,
  parameter int unsigned RST_M = 32,
  parameter int unsigned RST_S = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            pend_vld,
  input  logic [M_W-1:0]  pend_main,
  input  logic [SW_W-1:0] pend_swal,
  output modsel_e         sel,
  output logic            boundary,
  output logic [M_W-1:0]  act_main,
  output logic [SW_W-1:0] act_swal,
  output logic            fb_pulse
);
  logic [M_W-1:0]  m_cnt;
  logic [SW_W-1:0] s_left;

  assign sel      = (s_left != '0) ? MOD_PLUS : MOD_BASE;
  assign boundary = tick && (m_cnt == act_main - M_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt    <= '0;
      s_left   <= SW_W'(RST_S);
      act_main <= M_W'(RST_M);
      act_swal <= SW_W'(RST_S);
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= boundary;
      if (boundary) begin
        m_cnt <= '0;
        if (pend_vld) begin
          act_main <= pend_main;
          act_swal <= pend_swal;
          s_left   <= pend_swal;
        end else begin
          s_left   <= act_swal;
        end
      end else if (tick) begin
        m_cnt <= m_cnt + 1'b1;
        if (s_left != '0) s_left <= s_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import sw_div_pkg::*;
#(
  parameter int unsigned M_W   = 10,
  parameter int unsigned SW_W  = 5,
  parameter int unsigned RST_M = 32,
  parameter int unsigned RST_S = 0
) (
  input  logic            clk_div8,
  input  logic            rst_n,
  input  logic            ld_req,
  input  logic            ld_wide,
  input  logic [M_W-1:0]  ld_main,
  input  logic [SW_W-1:0] ld_swal,
  output logic            fb_pulse,
  output logic            range_err
);
  modsel_e         sel;
  logic            tick;
  logic            boundary;
  logic            pend_vld;
  logic [M_W-1:0]  pend_main;
  logic [SW_W-1:0] pend_swal;
  logic [M_W-1:0]  act_main;
  logic [SW_W-1:0] act_swal;

  sw_ratio_gate #(.M_W(M_W), .SW_W(SW_W)) gate_i (
    .clk(clk_div8), .rst_n(rst_n), .ld_req(ld_req), .ld_wide(ld_wide),
    .ld_main(ld_main), .ld_swal(ld_swal), .take(boundary),
    .pend_vld(pend_vld), .pend_main(pend_main), .pend_swal(pend_swal),
    .range_err(range_err)
  );

  sw_dual_modulus #(.SW_W(SW_W)) dm_i (
    .clk(clk_div8), .rst_n(rst_n), .sel(sel), .tick(tick)
  );

  sw_count_chain #(.M_W(M_W), .SW_W(SW_W), .RST_M(RST_M), .RST_S(RST_S)) chain_i (
    .clk(clk_div8), .rst_n(rst_n), .tick(tick), .pend_vld(pend_vld),
    .pend_main(pend_main), .pend_swal(pend_swal), .sel(sel),
    .boundary(boundary), .act_main(act_main), .act_swal(act_swal),
    .fb_pulse(fb_pulse)
  );
endmodule

// File: rtl/sw_div_chk.sv
module sw_div_chk #(
  parameter int unsigned M_W   = 10,
  parameter int unsigned SW_W  = 5,
  parameter int unsigned RST_M = 32,
  parameter int unsigned RST_S = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_req,
  input logic            fb_pulse,
  input logic            range_err,
  input logic [M_W-1:0]  act_main,
  input logic [SW_W-1:0] act_swal
);
  localparam int unsigned CNT_W = M_W + SW_W;
  localparam logic [M_W-1:0] M_FLOOR = M_W'(1 << SW_W);

  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] exp_q;
  logic [CNT_W-1:0] act_n;

  assign act_n = (CNT_W'(act_main) << SW_W) + CNT_W'(act_swal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      exp_q   <= (CNT_W'(RST_M) << SW_W) + CNT_W'(RST_S);
    end else begin
      since_q <= (fb_pulse ? '0 : since_q) + 1'b1;
      if (fb_pulse) exp_q <= act_n;
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> since_q == exp_q);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);
  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_pulse |-> ($stable(act_main) && $stable(act_swal)));
  // R6
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> act_main >= M_FLOOR);
  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> $past(ld_req));
endmodule

bind swallow_divider sw_div_chk #(
  .M_W(M_W), .SW_W(SW_W), .RST_M(RST_M), .RST_S(RST_S)
) chk_i (
  .clk(clk_div8), .rst_n(rst_n), .ld_req(ld_req), .fb_pulse(fb_pulse),
  .range_err(range_err), .act_main(act_main), .act_swal(act_swal)
);

// File: tb/swallow_divider_tb_top.sv
`timescale 1ns/1ps
module swallow_divider_tb_top;
  localparam int unsigned M_W = 7;
  localparam int unsigned SW_W = 3;
  localparam int unsigned RST_M = 8;
  localparam int unsigned RST_S = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_req = 1'b0;
  logic ld_wide = 1'b1;
  logic [M_W-1:0] ld_main = '0;
  logic [SW_W-1:0] ld_swal = '0;
  logic fb_pulse, range_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_pulse_cyc = 0;
  int pulse_cnt = 0;
  int gap_log [0:1023];
  int cur_n;

  always #2 clk = ~clk;

  swallow_divider #(.M_W(M_W), .SW_W(SW_W), .RST_M(RST_M), .RST_S(RST_S)) dut_i (
    .clk_div8(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_wide(ld_wide),
    .ld_main(ld_main), .ld_swal(ld_swal), .fb_pulse(fb_pulse), .range_err(range_err)
  );

  // Pulse monitor: records the spacing of pulses in cycles.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (fb_pulse) begin
        gap_log[pulse_cnt % 1024] = cyc - last_pulse_cyc;
        last_pulse_cyc = cyc;
        pulse_cnt = pulse_cnt + 1;
      end
    end
  end

  function automatic int eff_m(input int m, input bit wide);
    return wide ? m : (m % (1 << (M_W-1)));
  endfunction

  function automatic int ratio_of(input int m, input int s, input bit wide);
    return (eff_m(m, wide) << SW_W) + s;
  endfunction

  function automatic bit in_range(input int m, input bit wide);
    return eff_m(m, wide) >= (1 << SW_W);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Wait for the k-th pulse (0-based) and return its gap.
  task automatic gap_at(input int k, output int g);
    wait (pulse_cnt > k);
    g = gap_log[k % 1024];
  endtask

  // One-cycle load request driven at a negedge; returns range_err seen next negedge.
  task automatic load(input int m, input int s, input bit wide, output bit err);
    ld_req = 1'b1; ld_main = M_W'(m); ld_swal = SW_W'(s); ld_wide = wide;
    @(negedge clk);
    ld_req = 1'b0;
    err = range_err;
  endtask

  // Load right after a pulse, then check the running and the following period.
  task automatic step(input int m, input int s, input bit wide, input string tag);
    int k, g;
    bit err, ok;
    k = pulse_cnt;
    ok = in_range(m, wide);
    load(m, s, wide, err);
    chk(err == !ok, {tag, " R6 R8 range_err"}, int'(err), int'(!ok));
    gap_at(k, g);
    chk(g == cur_n, {tag, " R3 running period"}, g, cur_n);
    if (ok) cur_n = ratio_of(m, s, wide);
    gap_at(k + 1, g);
    chk(g == cur_n, {tag, " R1 next period"}, g, cur_n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin : main
    int g, k;
    bit err;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(fb_pulse == 1'b0, "R7 fb_pulse in reset", int'(fb_pulse), 0);
    chk(range_err == 1'b0, "R7 range_err in reset", int'(range_err), 0);
    #1 rst_n = 1'b1;
    cur_n = (RST_M << SW_W) + RST_S;
    @(negedge clk);
    chk(fb_pulse == 1'b0, "R7 fb_pulse after release", int'(fb_pulse), 0);
    gap_at(0, g);
    chk(g == cur_n, "R7 first pulse edge", g, cur_n);
    @(negedge clk);
    chk(fb_pulse == 1'b0, "R2 pulse width", int'(fb_pulse), 0);

    // Directed corners
    step(8, 7, 1'b1, "min M max S");
    step(127, 7, 1'b1, "max M wide");
    step(72, 3, 1'b0, "R5 narrow masks top bit");
    step(127, 0, 1'b0, "R5 narrow max");
    step(7, 5, 1'b1, "R6 below floor wide");
    step(66, 1, 1'b0, "R6 narrow masked below floor");
    step(20, 0, 1'b1, "S zero");

    // R4: two accepted requests in one period, last wins
    k = pulse_cnt;
    load(30, 2, 1'b1, err);
    load(40, 6, 1'b1, err);
    gap_at(k, g);
    chk(g == cur_n, "R4 running period kept", g, cur_n);
    cur_n = ratio_of(40, 6, 1'b1);
    gap_at(k + 1, g);
    chk(g == cur_n, "R4 last request applied", g, cur_n);

    // R6: rejected request keeps an earlier pending one
    k = pulse_cnt;
    load(12, 4, 1'b1, err);
    load(3, 1, 1'b1, err);
    chk(err == 1'b1, "R6 rejected flagged", int'(err), 1);
    gap_at(k, g);
    chk(g == cur_n, "R6 running period kept", g, cur_n);
    cur_n = ratio_of(12, 4, 1'b1);
    gap_at(k + 1, g);
    chk(g == cur_n, "R6 earlier pending kept", g, cur_n);

    // R3: request in the boundary cycle waits one more period
    k = pulse_cnt;
    wait (cyc == last_pulse_cyc + cur_n - 1);
    load(50, 5, 1'b1, err);
    gap_at(k, g);
    chk(g == cur_n, "R3 boundary-cycle request, ending period", g, cur_n);
    gap_at(k + 1, g);
    chk(g == cur_n, "R3 boundary-cycle request deferred", g, cur_n);
    cur_n = ratio_of(50, 5, 1'b1);
    gap_at(k + 2, g);
    chk(g == cur_n, "R3 boundary-cycle request applied", g, cur_n);

    // Constrained random
    gap_at(pulse_cnt, g);
    for (int i = 0; i < 16; i++) begin
      int m, s;
      bit w;
      m = int'($urandom_range(127, 0));
      s = int'($urandom_range(7, 0));
      w = 1'($urandom_range(1, 0));
      step(m, s, w, "random");
    end
    finish_up();
  end
endmodule